// File: doc/BRIEF.md
# Doorbell Capture Mailbox

This block lets two processors knock on each other's door. Each processor has a small timer-capture unit: a 16-bit capture register, a status register holding a capture flag, and a control register holding an interrupt enable. A free-running 16-bit counter runs on every clock and is shared by both units. When either processor performs a 16-bit write into one of two system-bus address windows, the capture unit of the targeted processor copies the current count into its capture register and raises its flag. If that processor has enabled the capture interrupt, its interrupt line goes high. Otherwise it must poll the flag.

The receiving processor clears the flag by writing a register value whose bit 7 is zero into its status register. The command word itself is passed through shared memory outside this block. The value written into a window is never used. Only the write event counts. Both windows sit inside a write-only range, and reads anywhere in that range return all ones. Processor index 0 is the primary and index 1 is the secondary.

Top module: `mbx_doorbell`

## Requirements
- R1: A system write with `sys_we`=1 and `sys_wide`=1 to an address in 0x1000000..0x17FFFFF (address bit 24 = 1, bit 23 = 0) sets the flag of processor 1 on the next clock edge and leaves processor 0 unchanged.
- R2: The same kind of write to 0x1800000..0x1FFFFFF (bits 24 and 23 both 1) sets the flag of processor 0 on the next clock edge.
- R3: Local register select 0 reads the status word. The flag appears in bit 7 and every other bit reads 0.
- R4: A local write to select 0 with data bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged.
- R5: Select 1 reads the capture-interrupt enable in bit 7, which is loaded from data bit 7 on a write. `irq[i]` is high exactly when flag and enable of processor i are both set.
- R6: When a doorbell and a flag clear for the same processor fall in the same cycle, the flag ends set.
- R7: On a doorbell, select 2 of the targeted processor afterwards reads the counter value that was present in the cycle of the write.
- R8: Select 3 reads the free-running counter. It increments on every clock edge out of reset and wraps from 0xFFFF to 0.
- R9: A read (`sys_rd`=1) with address bit 24 = 1 returns 0xFFFF on `sys_rdata` one cycle later. Any other read returns 0, and `sys_rdata` is 0 in cycles with no read.
- R10: Writes have no effect on any flag or capture register when they are system writes with `sys_wide`=0, system writes with address bit 24 = 0, or local writes to select 2 or 3.
- R11: During reset every flag, enable, capture register and the counter are zero, `irq` is 0 and `sys_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_we | input | 1 | System-bus write strobe |
| sys_wide | input | 1 | 1 when the system access is 16 bits wide |
| sys_rd | input | 1 | System-bus read strobe |
| sys_addr | input | ADDR_W (25) | System-bus byte address |
| sys_rdata | output | W (16) | Registered read data for the window range |
| loc_we | input | 2 | Per-processor local register write strobe |
| loc_sel | input | 4 | Per-processor register select, 2 bits each (0 status, 1 enable, 2 capture, 3 counter) |
| loc_wdata | input | 2*W (32) | Per-processor local write data |
| loc_rdata | output | 2*W (32) | Per-processor local read data, combinational from the selected register |
| irq | output | 2 | Per-processor capture interrupt |

## Verification
A flag held in the wrong state shows on the status read of its processor in the same cycle. If the enable is set, it also shows on `irq` within the same cycle. A lost or extra doorbell therefore shows one edge after the system write. A counter that skips or stalls shows on a select-3 read right away. It also corrupts the next capture value, which shows one edge after the next doorbell. The reference model is compared on every clock, so any such divergence is reported in the first cycle it reaches a port.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int NCPU     = 2;
    localparam int SEL_W    = 2;
    localparam int FLAG_BIT = 7;

    typedef enum logic [SEL_W-1:0] {
        REG_STAT = 2'd0,
        REG_CTRL = 2'd1,
        REG_CAPT = 2'd2,
        REG_CNT  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mbx_window_decode.sv
module mbx_window_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_we,
    input  logic              sys_wide,
    input  logic              sys_rd,
    input  logic [ADDR_W-1:0] sys_addr,
    output logic [NCPU-1:0]   ring,
    output logic [W-1:0]      sys_rdata
);
    localparam int WIN_BIT  = ADDR_W - 1;
    localparam int PICK_BIT = ADDR_W - 2;

    typedef struct packed {
        logic [W-1:0] rdata;
    } dec_st_t;

    dec_st_t dec_d, dec_q;
    logic    in_win;
    logic    hit;
    logic    unused_addr_low;

    assign in_win          = sys_addr[WIN_BIT];
    assign unused_addr_low = ^sys_addr[PICK_BIT-1:0];

    always_comb begin
        dec_d = dec_q;
        hit   = sys_we && sys_wide && in_win;
        // upper window rings processor 0, lower window rings processor 1
        ring[0] = hit && sys_addr[PICK_BIT];
        ring[1] = hit && !sys_addr[PICK_BIT];
        dec_d.rdata = '0;
        if (sys_rd && in_win) begin
            dec_d.rdata = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign sys_rdata = dec_q.rdata;
endmodule

// File: rtl/mbx_free_counter.sv
module mbx_free_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.cnt = cnt_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.cnt;
endmodule

// File: rtl/mbx_capture_unit.sv
module mbx_capture_unit
    import mbx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ring,
    input  logic [W-1:0]     count,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    output logic             irq,
    output logic             flag,
    output logic             ien,
    output logic [W-1:0]     capt
);
    typedef struct packed {
        logic         flag;
        logic         ien;
        logic [W-1:0] capt;
    } cap_st_t;

    cap_st_t cap_d, cap_q;
    logic    wr_stat;
    logic    wr_ctrl;
    logic    unused_wdata;

    assign unused_wdata = ^{reg_wdata[W-1:FLAG_BIT+1], reg_wdata[FLAG_BIT-1:0]};

    always_comb begin
        cap_d   = cap_q;
        wr_stat = reg_we && (reg_sel == REG_STAT);
        wr_ctrl = reg_we && (reg_sel == REG_CTRL);
        if (wr_stat && !reg_wdata[FLAG_BIT]) begin
            cap_d.flag = 1'b0;
        end
        if (wr_ctrl) begin
            cap_d.ien = reg_wdata[FLAG_BIT];
        end
        // a doorbell is applied last so it wins over a clear
        if (ring) begin
            cap_d.flag = 1'b1;
            cap_d.capt = count;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            REG_STAT: reg_rdata[FLAG_BIT] = cap_q.flag;
            REG_CTRL: reg_rdata[FLAG_BIT] = cap_q.ien;
            REG_CAPT: reg_rdata           = cap_q.capt;
            default:  reg_rdata           = count;
        endcase
    end

    assign irq  = cap_q.flag && cap_q.ien;
    assign flag = cap_q.flag;
    assign ien  = cap_q.ien;
    assign capt = cap_q.capt;
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int W      = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sys_we,
    input  logic                  sys_wide,
    input  logic                  sys_rd,
    input  logic [ADDR_W-1:0]     sys_addr,
    output logic [W-1:0]          sys_rdata,
    input  logic [NCPU-1:0]       loc_we,
    input  logic [NCPU*SEL_W-1:0] loc_sel,
    input  logic [NCPU*W-1:0]     loc_wdata,
    output logic [NCPU*W-1:0]     loc_rdata,
    output logic [NCPU-1:0]       irq
);
    logic [NCPU-1:0]   ring;
    logic [NCPU-1:0]   flag_v;
    logic [NCPU-1:0]   ien_v;
    logic [NCPU*W-1:0] capt_v;
    logic [W-1:0]      cnt_v;

    mbx_window_decode #(.ADDR_W(ADDR_W), .W(W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_we    (sys_we),
        .sys_wide  (sys_wide),
        .sys_rd    (sys_rd),
        .sys_addr  (sys_addr),
        .ring      (ring),
        .sys_rdata (sys_rdata)
    );

    mbx_free_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cnt_v)
    );

    for (genvar gi = 0; gi < NCPU; gi++) begin : g_cpu
        mbx_capture_unit #(.W(W)) u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .ring      (ring[gi]),
            .count     (cnt_v),
            .reg_we    (loc_we[gi]),
            .reg_sel   (loc_sel[gi*SEL_W +: SEL_W]),
            .reg_wdata (loc_wdata[gi*W +: W]),
            .reg_rdata (loc_rdata[gi*W +: W]),
            .irq       (irq[gi]),
            .flag      (flag_v[gi]),
            .ien       (ien_v[gi]),
            .capt      (capt_v[gi*W +: W])
        );
    end
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int W      = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCPU-1:0]       ring,
    input logic [NCPU-1:0]       flag,
    input logic [NCPU-1:0]       ien,
    input logic [NCPU*W-1:0]     capt,
    input logic [W-1:0]          cnt,
    input logic [NCPU-1:0]       irq,
    input logic                  sys_rd,
    input logic [ADDR_W-1:0]     sys_addr,
    input logic [W-1:0]          sys_rdata,
    input logic [NCPU-1:0]       loc_we,
    input logic [NCPU*SEL_W-1:0] loc_sel,
    input logic [NCPU*W-1:0]     loc_wdata
);
    logic past_ok;
    logic unused_chk_bits;

    assign unused_chk_bits = ^{loc_wdata, sys_addr};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> cnt == W'($past(cnt) + 1'b1));

    p_window_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rd && sys_addr[ADDR_W-1]) |=> sys_rdata == {W{1'b1}});

    for (genvar gi = 0; gi < NCPU; gi++) begin : g_chk
        logic clr;
        assign clr = loc_we[gi] && (loc_sel[gi*SEL_W +: SEL_W] == REG_STAT)
                     && !loc_wdata[gi*W + FLAG_BIT];

        // covers R1 and R2: the targeted flag is set after a doorbell
        p_ring_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
            ring[gi] |=> flag[gi]);

        p_ring_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ring[gi] && clr) |=> flag[gi]);

        p_clear_drops_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !ring[gi]) |=> !flag[gi]);

        p_capture_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ring[gi] |=> capt[gi*W +: W] == $past(cnt));

        p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
            irq[gi] |-> (flag[gi] && ien[gi]));

        p_no_spurious_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $rose(flag[gi])) |-> $past(ring[gi]));
    end
endmodule

bind mbx_doorbell mbx_doorbell_chk #(.ADDR_W(ADDR_W), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring      (ring),
    .flag      (flag_v),
    .ien       (ien_v),
    .capt      (capt_v),
    .cnt       (cnt_v),
    .irq       (irq),
    .sys_rd    (sys_rd),
    .sys_addr  (sys_addr),
    .sys_rdata (sys_rdata),
    .loc_we    (loc_we),
    .loc_sel   (loc_sel),
    .loc_wdata (loc_wdata)
);

// File: tb/tb_mbx_doorbell.sv
module tb_mbx_doorbell;
    localparam int AW = 25;
    localparam int W  = 16;
    localparam int N  = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sys_we, sys_wide, sys_rd;
    logic [AW-1:0] sys_addr;
    logic [W-1:0]  sys_rdata;
    logic [N-1:0]  loc_we;
    logic [2*N-1:0] loc_sel;
    logic [N*W-1:0] loc_wdata;
    logic [N*W-1:0] loc_rdata;
    logic [N-1:0]  irq;

    always #2 clk = ~clk;

    mbx_doorbell #(.ADDR_W(AW), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .sys_we(sys_we), .sys_wide(sys_wide),
        .sys_rd(sys_rd), .sys_addr(sys_addr), .sys_rdata(sys_rdata),
        .loc_we(loc_we), .loc_sel(loc_sel), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int m_flag[N];
    int m_ien[N];
    int m_capt[N];
    int m_cnt;
    int m_rd;
    string sel_tag[4] = '{"R3", "R5", "R7", "R8"};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input int i);
        int s = int'(loc_sel[i*2 +: 2]);
        case (s)
            0: return m_flag[i] << 7;
            1: return m_ien[i] << 7;
            2: return m_capt[i];
            default: return m_cnt;
        endcase
    endfunction

    function automatic int slice(input int i);
        return int'(loc_rdata[i*W +: W]);
    endfunction

    // one clock: advance the reference model with the held inputs, then compare
    task automatic cyc();
        bit hit;
        @(posedge clk);
        #1;
        hit  = sys_we && sys_wide && sys_addr[AW-1];
        m_rd = (sys_rd && sys_addr[AW-1]) ? 'hFFFF : 0;
        for (int i = 0; i < N; i++) begin
            bit rg = hit && (sys_addr[AW-2] ? (i == 0) : (i == 1));
            int s  = int'(loc_sel[i*2 +: 2]);
            if (loc_we[i] && s == 0 && !loc_wdata[i*W + 7]) m_flag[i] = 0;
            if (loc_we[i] && s == 1) m_ien[i] = loc_wdata[i*W + 7];
            if (rg) begin
                m_flag[i] = 1;
                m_capt[i] = m_cnt;
            end
        end
        m_cnt = (m_cnt + 1) & 'hFFFF;
        chk(int'(sys_rdata) == m_rd, "R9", int'(sys_rdata), m_rd);
        for (int i = 0; i < N; i++) begin
            int ei = (m_flag[i] != 0 && m_ien[i] != 0) ? 1 : 0;
            chk(int'(irq[i]) == ei, "R5", int'(irq[i]), ei);
            chk(slice(i) == model_read(i), sel_tag[int'(loc_sel[i*2 +: 2])],
                slice(i), model_read(i));
        end
    endtask

    task automatic idle();
        sys_we = 0; sys_rd = 0; loc_we = '0; sys_wide = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int e;
        rst_n = 0; sys_we = 0; sys_wide = 0; sys_rd = 0; sys_addr = '0;
        loc_we = '0; loc_sel = '0; loc_wdata = '0;
        for (int i = 0; i < N; i++) begin
            m_flag[i] = 0; m_ien[i] = 0; m_capt[i] = 0;
        end
        m_cnt = 0; m_rd = 0;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state on every register select
        for (int s = 0; s < 4; s++) begin
            loc_sel = {2'(s), 2'(s)};
            #1;
            chk(loc_rdata == '0, "R11", int'(loc_rdata[W-1:0]), 0);
        end
        chk(irq == '0, "R11", int'(irq), 0);
        chk(sys_rdata == '0, "R11", int'(sys_rdata), 0);
        rst_n = 1;
        idle();
        loc_sel = '0;

        // R1: lower window rings processor 1 only
        sys_we = 1; sys_addr = 25'h1000000;
        cyc();
        chk(slice(1) == 'h80, "R1", slice(1), 'h80);
        chk(slice(0) == 0, "R1", slice(0), 0);

        // R2: upper window rings processor 0
        sys_addr = 25'h1FFFFFE;
        cyc();
        chk(slice(0) == 'h80, "R2", slice(0), 'h80);

        // R4: clear with bit 7 low, keep with bit 7 high
        idle();
        loc_we = 2'b01; loc_wdata = '0;
        cyc();
        chk(slice(0) == 0, "R4", slice(0), 0);
        loc_we = 2'b10; loc_wdata = {16'h0080, 16'h0000};
        cyc();
        chk(slice(1) == 'h80, "R4", slice(1), 'h80);
        loc_wdata = {16'h7F7F, 16'h0000};
        cyc();
        chk(slice(1) == 0, "R4", slice(1), 0);

        // R10: narrow write and out-of-window write do nothing
        idle();
        sys_we = 1; sys_wide = 0; sys_addr = 25'h1000000;
        cyc();
        chk(slice(1) == 0, "R10", slice(1), 0);
        sys_wide = 1; sys_addr = 25'h0800000;
        cyc();
        chk(loc_rdata == '0, "R10", int'(loc_rdata[W-1:0]), 0);

        // R5: enable, then doorbell raises irq
        idle();
        loc_we = 2'b11; loc_sel = {2'd1, 2'd1}; loc_wdata = {16'h0080, 16'h0080};
        cyc();
        chk(slice(0) == 'h80, "R5", slice(0), 'h80);
        chk(irq == 2'b00, "R5", int'(irq), 0);
        idle();
        sys_we = 1; sys_addr = 25'h1800000;
        cyc();
        chk(irq == 2'b01, "R5", int'(irq), 1);

        // R6: doorbell and clear together keep the flag
        loc_sel = '0; loc_we = 2'b01; loc_wdata = '0;
        cyc();
        chk(irq[0] == 1'b1, "R6", int'(irq[0]), 1);
        chk(slice(0) == 'h80, "R6", slice(0), 'h80);

        // R7: capture holds the count of the write cycle
        idle();
        e = m_cnt;
        sys_we = 1; sys_addr = 25'h1000000;
        cyc();
        sys_we = 0; loc_sel = {2'd2, 2'd0};
        #1;
        chk(slice(1) == e, "R7", slice(1), e);

        // R10: writes to capture and counter selects are ignored
        loc_we = 2'b10; loc_wdata = {16'h1234, 16'h0000};
        cyc();
        chk(slice(1) == e, "R10", slice(1), e);
        loc_sel = {2'd3, 2'd0};
        cyc();
        chk(slice(1) == m_cnt, "R10", slice(1), m_cnt);

        // R9: window read returns all ones, other reads zero
        idle();
        sys_rd = 1; sys_addr = 25'h1234567;
        cyc();
        chk(int'(sys_rdata) == 'hFFFF, "R9", int'(sys_rdata), 'hFFFF);
        sys_addr = 25'h0234567;
        cyc();
        chk(int'(sys_rdata) == 0, "R9", int'(sys_rdata), 0);

        // mixed traffic, compared against the model every clock
        for (int k = 0; k < 40000; k++) begin
            int r = int'($urandom % 3);
            sys_we   = ($urandom % 6) == 0;
            sys_wide = ($urandom % 4) != 0;
            sys_rd   = ($urandom % 5) == 0;
            sys_addr = (r == 0) ? 25'h1000000 + AW'($urandom % 25'h800000) :
                       (r == 1) ? 25'h1800000 + AW'($urandom % 25'h800000) :
                                  AW'($urandom % 25'h1000000);
            loc_we    = N'($urandom % 4) & N'(($urandom % 3) == 0 ? 3 : 0);
            loc_sel   = (2*N)'($urandom);
            loc_wdata = (N*W)'($urandom);
            cyc();
        end

        // R8: counter wraps from 0xFFFF to 0
        idle();
        loc_sel = {2'd3, 2'd3};
        while (m_cnt != 'hFFFF) cyc();
        chk(slice(0) == 'hFFFF, "R8", slice(0), 'hFFFF);
        cyc();
        chk(slice(0) == 0, "R8", slice(0), 0);
        cyc();
        chk(slice(1) == 1, "R8", slice(1), 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule